// File: doc/BRIEF.md
# Merging Packet Reassembly Unit

This block sits on the output side of a cell switch. Each arriving cell carries a fixed-width payload token, the number of its incoming virtual channel, an end-of-packet flag, and two port tags (the source port it came in on and the destination port it is heading to). The incoming channel number picks a logical reassembly queue. Every queue, and the output queue as well, is a linked list of slots in one shared cell pool. A cell stays in its queue until the end-of-packet cell of its packet arrives. Only then does the packet become eligible for transfer.

Queues that hold finished packets take turns on one transfer path in round-robin order. The winner keeps the path until its last cell has been moved. Each move relinks one cell from its reassembly queue to the output queue. During the move the outgoing channel identifier is written from a per-channel translation vector, and several incoming channels may name the same outgoing identifier. Because packets reach the output queue whole and one at a time, the output stream never mixes cells from two packets, even when those packets share an outgoing identifier.

If a cell arrives while the pool is full, the cell is lost and so is the rest of its packet. The partial packet already stored is released, and every cell that follows on that channel is thrown away up to and including the next end-of-packet cell. A saturating counter records every lost cell. A one-cycle pulse on a per-channel line reports each packet that reassembles successfully.

Top module: `vcm_reasm`

## Requirements
- R1: After reset, out_valid, pkt_done and drop_count are all zero.
- R2: A cell never appears at the output before the end-of-packet cell of its packet has been accepted. There is no cut-through.
- R3: The cells of one packet leave back to back in arrival order, and only the last one has out_eop set. No cell of any other packet appears between them, even when the two packets were interleaved at the input.
- R4: out_vci equals the translation entry of the cell's incoming channel c, which is bits [16c+15:16c] of vci_map. Channels with equal entries are merged onto one identifier.
- R5: out_src_port and out_dst_port repeat the tags that arrived with the cell.
- R6: When several channels hold finished packets, the grant goes to the first ready channel after the last granted one in ascending order, wrapping from 7 to 0.
- R7: A cell that arrives while all 256 pool slots are in use is dropped. Its channel's stored partial packet is released, the following cells of that channel are dropped through the next end-of-packet cell, and drop_count increases by one for every dropped cell.
- R8: Slots released by a drop can be used again at once, and a later packet on the same channel reassembles normally.
- R9: pkt_done bit c pulses for exactly one cycle, in the cycle after channel c's end-of-packet cell is accepted. It does not pulse for a dropped packet.
- R10: While out_valid is high and out_ready is low, the output cell is held stable. With out_ready held high, one cell leaves per cycle without gaps.
- R11: A single channel may take up nearly the whole pool (250 of 256 slots in one packet).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arriving cell present |
| in_vc | input | 3 | Incoming channel number (queue select) |
| in_src_port | input | 4 | Source port tag |
| in_dst_port | input | 4 | Destination port tag |
| in_eop | input | 1 | Last cell of packet |
| in_data | input | 32 | Cell payload token |
| vci_map | input | 128 | Translation table, 16 bits per incoming channel |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Downstream accepts the output cell |
| out_vci | output | 16 | Rewritten outgoing identifier |
| out_src_port | output | 4 | Source port tag of output cell |
| out_dst_port | output | 4 | Destination port tag of output cell |
| out_eop | output | 1 | Output cell ends its packet |
| out_data | output | 32 | Output payload token |
| pkt_done | output | 8 | Per-channel packet-reassembled pulse |
| drop_count | output | 16 | Saturating count of dropped cells |

## Verification
The bench interleaves cells of two channels that share one outgoing identifier. A design that forwarded cells as they arrived, or that let two transfers overlap, would mix cells of different packets at the output. Three single-cell packets finish, in a deliberately scrambled order, while a long packet is still moving. A first-come or fixed-priority arbiter would send them out in a different order from the rotating one. The pool is then filled with the output stalled until a packet overflows midway. A design that kept the stored partial, stopped discarding once space came free, or leaked slots would deliver a damaged packet, miscount the drops, or refuse the next packet. Throughout the run, every output cell is checked against its source channel, sequence, index, tags and translated identifier.

// File: rtl/vcm_reasm.sv
`timescale 1ns/1ps
module vcm_reasm #(
  parameter int NUM_VC = 8,
  parameter int VCI_W  = 16,
  parameter int POOL   = 256,
  parameter int DW     = 32,
  parameter int PW     = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [$clog2(NUM_VC)-1:0] in_vc,
  input  logic [PW-1:0]           in_src_port,
  input  logic [PW-1:0]           in_dst_port,
  input  logic                    in_eop,
  input  logic [DW-1:0]           in_data,
  input  logic [NUM_VC*VCI_W-1:0] vci_map,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [VCI_W-1:0]        out_vci,
  output logic [PW-1:0]           out_src_port,
  output logic [PW-1:0]           out_dst_port,
  output logic                    out_eop,
  output logic [DW-1:0]           out_data,
  output logic [NUM_VC-1:0]       pkt_done,
  output logic [CNT_W-1:0]        drop_count
);
  localparam int VCW = $clog2(NUM_VC);
  localparam int AW  = $clog2(POOL);
  localparam int CW  = $clog2(POOL + 1);
  localparam int TW  = CW + VCW + 1;

  // cell pool
  logic [DW-1:0]    m_data [POOL];
  logic [AW-1:0]    m_next [POOL];
  logic [VCI_W-1:0] m_vci  [POOL];
  logic [PW-1:0]    m_src  [POOL];
  logic [PW-1:0]    m_dst  [POOL];
  logic [VCW-1:0]   m_vc   [POOL];
  logic             m_eop  [POOL];
  logic [POOL-1:0]  used, part;

  // reassembly queues
  logic [AW-1:0] q_head [NUM_VC];
  logic [AW-1:0] q_tail [NUM_VC];
  logic [AW-1:0] q_ctail[NUM_VC];
  logic [CW-1:0] q_cnt  [NUM_VC];
  logic [CW-1:0] q_pcnt [NUM_VC];
  logic [CW-1:0] q_pkts [NUM_VC];
  logic [NUM_VC-1:0] disc;

  // output queue and arbiter
  logic [AW-1:0]  o_head, o_tail;
  logic [CW-1:0]  o_cnt;
  logic           busy;
  logic [VCW-1:0] gvc, rr, pick;
  logic [NUM_VC-1:0] rdy;

  logic          full, accept, kill, dep, pop, peop, eop_in;
  logic [AW-1:0] free_idx, pcell;
  logic [POOL-1:0] kmask, sel, dmask;
  logic [TW-1:0] total;

  assign full   = &used;
  assign accept = in_valid && !disc[in_vc] && !full;
  assign kill   = in_valid && !disc[in_vc] && full;
  assign eop_in = accept && in_eop;
  assign pop    = busy;
  assign pcell  = q_head[gvc];
  assign peop   = m_eop[pcell];
  assign dep    = out_valid && out_ready;

  assign out_valid    = (o_cnt != '0);
  assign out_data     = m_data[o_head];
  assign out_vci      = m_vci[o_head];
  assign out_src_port = m_src[o_head];
  assign out_dst_port = m_dst[o_head];
  assign out_eop      = m_eop[o_head];

  always_comb begin
    free_idx = '0;
    for (int i = POOL - 1; i >= 0; i--)
      if (!used[i]) free_idx = AW'(i);
  end

  always_comb begin
    for (int i = 0; i < POOL; i++) begin
      kmask[i] = part[i] && (m_vc[i] == in_vc);
      sel[i]   = accept && (free_idx == AW'(i));
      dmask[i] = dep && (o_head == AW'(i));
    end
  end

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) rdy[v] = (q_pkts[v] != '0);
    pick = '0;
    for (int i = NUM_VC; i >= 1; i--)
      if (rdy[(int'(rr) + i) % NUM_VC]) pick = VCW'((int'(rr) + i) % NUM_VC);
  end

  always_comb begin
    total = TW'(o_cnt);
    for (int v = 0; v < NUM_VC; v++) total = total + TW'(q_cnt[v]);
  end

  // pool storage, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      m_data[free_idx] <= in_data;
      m_src[free_idx]  <= in_src_port;
      m_dst[free_idx]  <= in_dst_port;
      m_eop[free_idx]  <= in_eop;
      m_vc[free_idx]   <= in_vc;
      if (q_cnt[in_vc] != '0) m_next[q_tail[in_vc]] <= free_idx;
    end
    if (pop) begin
      m_vci[pcell] <= vci_map[gvc*VCI_W +: VCI_W];
      if (o_cnt != '0) m_next[o_tail] <= pcell;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      part <= '0;
      disc <= '0;
      o_head <= '0;
      o_tail <= '0;
      o_cnt <= '0;
      busy <= 1'b0;
      gvc <= '0;
      rr <= '0;
      pkt_done <= '0;
      drop_count <= '0;
      for (int v = 0; v < NUM_VC; v++) begin
        q_head[v] <= '0;
        q_tail[v] <= '0;
        q_ctail[v] <= '0;
        q_cnt[v] <= '0;
        q_pcnt[v] <= '0;
        q_pkts[v] <= '0;
      end
    end else begin
      used <= (used | sel) & ~dmask & ~(kill ? kmask : '0);
      part <= (part & ~((eop_in || kill) ? kmask : '0)) | (in_eop ? '0 : sel);

      pkt_done <= '0;
      if (eop_in) pkt_done[in_vc] <= 1'b1;
      if (in_valid && !accept && drop_count != '1) drop_count <= drop_count + 1'b1;

      for (int v = 0; v < NUM_VC; v++) begin
        if (in_valid && in_vc == VCW'(v)) begin
          if (disc[v]) disc[v] <= !in_eop;
          else if (full) disc[v] <= !in_eop;
        end
        q_cnt[v] <= q_cnt[v]
                  + CW'(accept && in_vc == VCW'(v))
                  - CW'(pop && gvc == VCW'(v))
                  - ((kill && in_vc == VCW'(v)) ? q_pcnt[v] : '0);
        if (accept && in_vc == VCW'(v)) q_pcnt[v] <= in_eop ? '0 : q_pcnt[v] + 1'b1;
        else if (kill && in_vc == VCW'(v)) q_pcnt[v] <= '0;
        q_pkts[v] <= q_pkts[v] + CW'(eop_in && in_vc == VCW'(v))
                   - CW'(pop && peop && gvc == VCW'(v));
        if (pop && gvc == VCW'(v))
          q_head[v] <= (q_cnt[v] == CW'(1) && accept && in_vc == VCW'(v)) ? free_idx : m_next[q_head[v]];
        else if (accept && in_vc == VCW'(v) && q_cnt[v] == '0)
          q_head[v] <= free_idx;
        if (accept && in_vc == VCW'(v)) q_tail[v] <= free_idx;
        else if (kill && in_vc == VCW'(v)) q_tail[v] <= q_ctail[v];
        if (eop_in && in_vc == VCW'(v)) q_ctail[v] <= free_idx;
      end

      o_cnt <= o_cnt + CW'(pop) - CW'(dep);
      if (pop) o_tail <= pcell;
      if (dep) o_head <= (o_cnt == CW'(1) && pop) ? pcell : m_next[o_head];
      else if (pop && o_cnt == '0) o_head <= pcell;

      if (busy) begin
        if (peop) busy <= 1'b0;
      end else if (|rdy) begin
        busy <= 1'b1;
        gvc  <= pick;
        rr   <= pick;
      end
    end
  end

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_vci) && $stable(out_eop));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !peop |=> busy && $stable(gvc));

  // R9
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pkt_done));

  // R7
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 drop_count >= $past(drop_count));

  // R11
  pool_acct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used) == int'(total));
endmodule

// File: tb/tb_vcm_reasm.sv
`timescale 1ns/1ps
module tb_vcm_reasm;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_eop = 0, out_ready = 0;
  logic [2:0] in_vc = 0;
  logic [3:0] in_src_port = 0, in_dst_port = 0;
  logic [31:0] in_data = 0;
  logic [127:0] vci_map;
  logic out_valid, out_eop;
  logic [15:0] out_vci;
  logic [3:0] out_src_port, out_dst_port;
  logic [31:0] out_data;
  logic [7:0] pkt_done;
  logic [15:0] drop_count;

  always #10 clk = ~clk;

  vcm_reasm dut (.*);

  int checks = 0, errors = 0, cells = 0;
  int pseq [8];
  int plen [8][16];
  int log_vc [64];
  int log_seq [64];
  int log_n = 0;
  int cur_vc = -1, cur_seq = 0, exp_idx = 0;
  bit done = 0;

  function automatic logic [15:0] map_of(int v);
    return (v == 1 || v == 3) ? 16'h00AA : 16'h1000 + 16'(v);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // output monitor: R3 R4 R5
  always @(negedge clk) begin
    #5;
    if (rst_n && out_valid && out_ready) begin
      int v, s, ix;
      v = int'(out_data[31:24]);
      s = int'(out_data[23:16]);
      ix = int'(out_data[15:0]);
      cells++;
      if (cur_vc < 0) begin
        chk(ix == 0 && v < 8, "R3 packet start", ix, 0);
        cur_vc = v; cur_seq = s; exp_idx = 0;
      end else begin
        chk(v == cur_vc && s == cur_seq && ix == exp_idx, "R3 contiguity",
            out_data, {8'(cur_vc), 8'(cur_seq), 16'(exp_idx)});
      end
      if (v < 8) begin
        chk(out_vci == map_of(v), "R4 vci rewrite", out_vci, map_of(v));
        chk(out_src_port == 4'(v + 1) && out_dst_port == (4'hC ^ 4'(v)), "R5 tags",
            {out_src_port, out_dst_port}, {4'(v + 1), 4'hC ^ 4'(v)});
        chk(out_eop == (ix == plen[v][s & 15] - 1), "R3 eop position", out_eop, ix == plen[v][s & 15] - 1);
      end
      exp_idx++;
      if (out_eop) begin
        if (log_n < 64) begin log_vc[log_n] = cur_vc; log_seq[log_n] = cur_seq; end
        log_n++;
        cur_vc = -1;
      end
    end
  end

  task automatic send_cell(int v, int s, int ix, bit e);
    @(negedge clk);
    in_valid = 1; in_vc = 3'(v); in_eop = e;
    in_data = {8'(v), 8'(s), 16'(ix)};
    in_src_port = 4'(v + 1); in_dst_port = 4'hC ^ 4'(v);
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 0; in_eop = 0;
  endtask

  task automatic send_pkt(int v, int len);
    int s;
    s = pseq[v]; pseq[v]++;
    plen[v][s & 15] = len;
    for (int i = 0; i < len; i++) send_cell(v, s, i, i == len - 1);
  endtask

  task automatic drain();
    out_ready = 1;
    repeat (40) @(negedge clk);
    while (out_valid) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    #5;
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(drop_count == 0, "R1 drop_count", drop_count, 0);
    chk(pkt_done == 0, "R1 pkt_done", pkt_done, 0);
  endtask

  task automatic t_no_cut();
    bit seen;
    out_ready = 1; log_n = 0; seen = 0;
    pseq[2] = 0; plen[2][0] = 3;
    send_cell(2, 0, 0, 0);
    send_cell(2, 0, 1, 0);
    idle_in();
    repeat (10) begin @(negedge clk); #5; if (out_valid) seen = 1; end
    chk(!seen, "R2 no output before eop", seen, 0);
    send_cell(2, 0, 2, 1);
    idle_in(); #5;
    chk(pkt_done == 8'h04, "R9 done pulse", pkt_done, 8'h04);
    @(negedge clk); #5;
    chk(pkt_done == 8'h00, "R9 single cycle", pkt_done, 0);
    pseq[2] = 1;
    drain();
    chk(log_n == 1 && log_vc[0] == 2, "R2 packet delivered", log_n, 1);
  endtask

  task automatic t_merge();
    log_n = 0; out_ready = 1;
    plen[1][pseq[1] & 15] = 4; plen[3][pseq[3] & 15] = 4;
    for (int i = 0; i < 4; i++) begin
      send_cell(1, pseq[1], i, i == 3);
      send_cell(3, pseq[3], i, i == 3);
    end
    pseq[1]++; pseq[3]++;
    idle_in();
    drain();
    chk(log_n == 2, "R3 merged packet count", log_n, 2);
    chk(log_vc[0] == 1 && log_vc[1] == 3, "R4 merged order", {log_vc[0], log_vc[1]}, {32'd1, 32'd3});
  endtask

  task automatic t_rr();
    log_n = 0; out_ready = 1;
    send_pkt(5, 10);
    send_pkt(3, 1);
    send_pkt(1, 1);
    send_pkt(6, 1);
    idle_in();
    drain();
    chk(log_n == 4, "R6 packet count", log_n, 4);
    chk(log_vc[0] == 5 && log_vc[1] == 6 && log_vc[2] == 1 && log_vc[3] == 3, "R6 rotation order",
        {log_vc[0][7:0], log_vc[1][7:0], log_vc[2][7:0], log_vc[3][7:0]}, 32'h05060103);
  endtask

  task automatic t_overflow();
    logic [31:0] held;
    int c0;
    log_n = 0; out_ready = 0;
    send_pkt(0, 250);
    send_pkt(4, 10);
    idle_in(); #5;
    chk(pkt_done == 0, "R9 no pulse for dropped packet", pkt_done, 0);
    chk(drop_count == 4, "R7 drop count", drop_count, 4);
    send_pkt(4, 2);
    idle_in(); #5;
    chk(pkt_done == 8'h10, "R8 reuse pulse", pkt_done, 8'h10);
    repeat (3) @(negedge clk);
    #5; held = out_data;
    repeat (5) @(negedge clk);
    #5;
    chk(out_valid && out_data == held, "R10 hold while stalled", out_data, held);
    @(negedge clk);
    out_ready = 1; c0 = cells;
    repeat (249) @(negedge clk);
    #6;
    chk(cells - c0 == 250, "R10 one cell per cycle", cells - c0, 250);
    drain();
    chk(log_n == 2, "R11 packets delivered", log_n, 2);
    chk(log_vc[0] == 0 && log_vc[1] == 4 && log_seq[1] == 1, "R7 dropped packet absent",
        log_seq[1], 1);
    chk(drop_count == 4, "R7 count stable", drop_count, 4);
  endtask

  initial begin
    for (int v = 0; v < 8; v++) begin
      vci_map[v*16 +: 16] = map_of(v);
      pseq[v] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_no_cut();
    t_merge();
    t_rr();
    t_overflow();
    chk(cur_vc == -1, "R3 no open packet", cur_vc, -1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule